// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host reach the management registers of an external Ethernet PHY over a two-wire MDIO bus, using clause 22 frames. The host programs a command word, which holds the PHY address, the register number and the direction, and a 16-bit write value. It then sets a combined start/busy bit in a control word.

The block divides the system clock down to make MDC and shifts the full frame out on a tristate MDIO pin. On a read it releases the pin for the turnaround and the data phase and collects the PHY's 16 data bits. The hardware clears the busy bit when the frame is finished. A read result is valid in the read-data word from that point on.

A separate enable bit gates the bus. A start request is accepted only while that bit is being written as 1 and no frame is already running.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset MDC is low, the MDIO output enable is low, and reading the control word (host_addr 3) and the read-data word (host_addr 2) both return 0.
- R2: The command word (host_addr 0) keeps host_wdata[10:0] and reads them back with the upper bits as 0. Its bits [4:0] are the PHY register number, bits [9:5] are the PHY address, and bit 10 selects the operation (1 = read, 0 = write).
- R3: In the control word (host_addr 3), bit 3 is the enable and bit 0 is start/busy. A write with both bits set starts a frame, and bit 0 then reads 1 until the frame ends and 0 afterwards.
- R4: A write to the control word with bit 0 set and bit 3 clear starts no frame: no MDC edge is produced and bit 0 reads 0.
- R5: A start request made while a frame is running is ignored. The running frame completes with exactly 64 MDC rising edges, and its header keeps the command it was started with, even if the command word is rewritten meanwhile.
- R6: A write frame is 32 ones, then 01, then opcode 01, then the 5 PHY address bits, the 5 register bits, turnaround 10 and the 16 write-data bits. Every field is sent MSB first, the pin is driven for all 64 bits, and each bit is presented at an MDC rising edge.
- R7: A read frame sends the same preamble and start bits, opcode 10, and then the address and register bits. The output enable is high for the first 46 bits and low for the last 18 bits (turnaround and data).
- R8: On a read, the master samples MDIO at the MDC rising edges of the last 16 bits, MSB first, and the 16-bit result appears in the read-data word (host_addr 2) when busy clears. A write frame leaves the read-data word unchanged.
- R9: The MDC period is MDC_DIV system clocks with equal high and low halves. MDC is low while idle, and the driven MDIO value changes only where MDC falls.
- R10: The write-data word (host_addr 1) keeps host_wdata[15:0] and reads them back with the upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for one cycle |
| host_addr | input | 2 | Word select: 0 command, 1 write data, 2 read data, 3 control |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Read value of the selected word (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value to the pad |
| mdio_oe | output | 1 | MDIO pad drive enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
The bench builds the block with MDC_DIV = 4, which makes each MDC half period two system clocks and a whole frame 256 clocks. That keeps the bench short enough to run several full read and write frames, a restart attempt in the middle of a frame, and a disabled start. The exact MDC period and the rule that MDIO changes only on a falling MDC edge can be measured directly in nanoseconds. With the default divider of 50, MDC is 2.5 MHz from a 125 MHz clock. The bench does not build that configuration, but the half-period assertion counts against the same parameter.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  localparam int FRAME_BITS = 64;
  localparam int DATA_BITS  = 16;
  localparam int FIELD_BITS = 5;
  localparam int IDX_W      = $clog2(FRAME_BITS);
  localparam int TA_POS     = 46;   // first turnaround bit
  localparam int DATA_POS   = 48;   // first data bit
  localparam int CTRL_GO    = 0;
  localparam int CTRL_EN    = 3;

  typedef enum logic [1:0] {
    HR_CMD   = 2'd0,
    HR_WDATA = 2'd1,
    HR_RDATA = 2'd2,
    HR_CTRL  = 2'd3
  } host_reg_e;

  // command word layout: [10] read, [9:5] phy, [4:0] register
  typedef struct packed {
    logic                  rd;
    logic [FIELD_BITS-1:0] phy;
    logic [FIELD_BITS-1:0] regn;
  } mdio_cmd_t;

  // whole clause 22 frame, first bit on the wire at the MSB
  function automatic logic [FRAME_BITS-1:0] build_frame(mdio_cmd_t c,
                                                        logic [DATA_BITS-1:0] d);
    logic [1:0]           op;
    logic [1:0]           ta;
    logic [DATA_BITS-1:0] pay;
    op  = c.rd ? 2'b10 : 2'b01;
    ta  = c.rd ? 2'b11 : 2'b10;
    pay = c.rd ? {DATA_BITS{1'b1}} : d;
    return {{32{1'b1}}, 2'b01, op, c.phy, c.regn, ta, pay};
  endfunction

  // the master owns the pin for the whole write and the head of a read
  function automatic logic master_drives(logic rd, logic [IDX_W-1:0] idx);
    return !rd || (idx < IDX_W'(TA_POS));
  endfunction

  function automatic logic in_data_phase(logic [IDX_W-1:0] idx);
    return idx >= IDX_W'(DATA_POS);
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int MDC_DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = MDC_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          at_top;

  assign at_top   = (cnt == CW'(HALF - 1));
  assign rise_evt = run && at_top && !mdc;
  assign fall_evt = run && at_top && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_top) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  mdio_cmd_t             cmd,
  input  logic [DATA_BITS-1:0]  wdata,
  input  logic                  rise_evt,
  input  logic                  fall_evt,
  input  logic                  mdio_i,
  output logic                  busy,
  output logic                  rd_valid,
  output logic [DATA_BITS-1:0]  rd_word,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic [IDX_W-1:0]      bit_idx
);
  logic [FRAME_BITS-1:0] shreg;
  logic [DATA_BITS-1:0]  cap;
  logic [IDX_W-1:0]      idx;
  logic                  busy_q;
  logic                  rd_q;
  logic                  last_bit;
  logic                  finish;

  assign last_bit = (idx == IDX_W'(FRAME_BITS - 1));
  assign finish   = busy_q && rise_evt && last_bit;
  assign rd_valid = finish && rd_q;
  assign rd_word  = {cap[DATA_BITS-2:0], mdio_i};
  assign mdio_oe  = busy_q && master_drives(rd_q, idx);
  assign mdio_o   = mdio_oe && shreg[FRAME_BITS-1];
  assign busy     = busy_q;
  assign bit_idx  = idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg  <= '0;
      cap    <= '0;
      idx    <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
    end else if (start) begin
      shreg  <= build_frame(cmd, wdata);
      cap    <= '0;
      idx    <= '0;
      busy_q <= 1'b1;
      rd_q   <= cmd.rd;
    end else if (busy_q) begin
      if (fall_evt) begin
        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
        idx   <= idx + 1'b1;
      end
      if (rise_evt) begin
        if (rd_q && in_data_phase(idx)) cap <= rd_word;
        if (last_bit) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic [1:0]            host_addr,
  input  logic [31:0]           host_wdata,
  output logic [31:0]           host_rdata,
  input  logic                  busy,
  input  logic                  rd_valid,
  input  logic [DATA_BITS-1:0]  rd_word,
  output mdio_cmd_t             cmd,
  output logic [DATA_BITS-1:0]  wdata,
  output logic [DATA_BITS-1:0]  rd_hold,
  output logic                  en,
  output logic                  start
);
  localparam int CMD_W = $bits(mdio_cmd_t);

  logic wr_cmd, wr_wd, wr_ctl;

  assign wr_cmd = host_wr && (host_addr == HR_CMD);
  assign wr_wd  = host_wr && (host_addr == HR_WDATA);
  assign wr_ctl = host_wr && (host_addr == HR_CTRL);
  assign start  = wr_ctl && host_wdata[CTRL_GO] && host_wdata[CTRL_EN] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd     <= '0;
      wdata   <= '0;
      rd_hold <= '0;
      en      <= 1'b0;
    end else begin
      if (wr_cmd)   cmd     <= mdio_cmd_t'(host_wdata[CMD_W-1:0]);
      if (wr_wd)    wdata   <= host_wdata[DATA_BITS-1:0];
      if (wr_ctl)   en      <= host_wdata[CTRL_EN];
      if (rd_valid) rd_hold <= rd_word;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (host_addr)
      HR_CMD:   host_rdata[CMD_W-1:0]     = cmd;
      HR_WDATA: host_rdata[DATA_BITS-1:0] = wdata;
      HR_RDATA: host_rdata[DATA_BITS-1:0] = rd_hold;
      default: begin
        host_rdata[CTRL_EN] = en;
        host_rdata[CTRL_GO] = busy;
      end
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int MDC_DIV = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [1:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t            cmd;
  logic [DATA_BITS-1:0] wr_val;
  logic [DATA_BITS-1:0] rd_word;
  logic [DATA_BITS-1:0] rdata_q;
  logic [IDX_W-1:0]     bit_idx;
  logic                 busy, en_q, start, rd_valid;
  logic                 rise_evt, fall_evt;

  mdio_host_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .rd_valid(rd_valid), .rd_word(rd_word),
    .cmd(cmd), .wdata(wr_val), .rd_hold(rdata_q),
    .en(en_q), .start(start)
  );

  mdio_clkgen #(.MDC_DIV(MDC_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cmd(cmd), .wdata(wr_val),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .mdio_i(mdio_i),
    .busy(busy), .rd_valid(rd_valid), .rd_word(rd_word),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .bit_idx(bit_idx)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker #(
  parameter int MDC_DIV = 50
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        en_q,
  input logic [5:0]  bit_idx,
  input logic [15:0] rdata_q
);
  localparam int HALF = MDC_DIV / 2;

  logic        mdc_q;
  logic [15:0] hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= 1'b0;
      hold  <= '0;
    end else begin
      mdc_q <= mdc;
      if (mdc != mdc_q)       hold <= 16'd1;
      else if (hold != '1)    hold <= hold + 1'b1;
    end
  end

  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);  // R1
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> !mdc);  // R9
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));  // R9
  AST_MDC_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mdc != mdc_q) && !mdc) |-> (hold == 16'(HALF)));  // R9
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> en_q);  // R4
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (bit_idx >= $past(bit_idx)));  // R5
  AST_RDATA_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $fell(busy));  // R8
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.MDC_DIV(MDC_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .en_q(en_q), .bit_idx(bit_idx), .rdata_q(rdata_q)
);

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  localparam int DIV = 4;
  localparam time MDC_PERIOD = 32;   // DIV * 8 ns

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  mdio_mgmt_master #(.MDC_DIV(DIV)) i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #4 clk = ~clk;

  // pad-side observation
  logic        sh_o = 1'b0, sh_oe = 1'b0;
  logic [63:0] cap_o, cap_oe;
  int          rise_n = 0, fall_n = 0, viol = 0;
  time         last_rise = 0, period_t = 0;
  logic [15:0] phy_word = 16'h0;

  always @(negedge clk) begin
    if (mdc && sh_oe && mdio_oe && (mdio_o !== sh_o)) viol++;
    sh_o  = mdio_o;
    sh_oe = mdio_oe;
  end

  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], sh_o};
    cap_oe = {cap_oe[62:0], sh_oe};
    rise_n++;
    if (last_rise != 0) period_t = $time - last_rise;
    last_rise = $time;
  end

  always @(negedge mdc) begin
    fall_n++;
    if (fall_n >= 48 && fall_n <= 63) mdio_i = phy_word[63-fall_n];
    else mdio_i = 1'b1;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic clear_mon();
    rise_n = 0; fall_n = 0; last_rise = 0; period_t = 0; viol = 0;
    cap_o = '0; cap_oe = '0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    bit done = 0;
    for (int i = 0; i < 2000; i++) begin
      host_read(2'd3, v);
      if (!v[0]) begin done = 1; break; end
    end
    if (!done) check({tag, " watchdog: busy never cleared"}, 64'd1, 64'd0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 mdc after reset", {63'd0, mdc}, 64'd0);
    check("R1 oe after reset", {63'd0, mdio_oe}, 64'd0);
    host_read(2'd3, v); check("R1 control after reset", {32'd0, v}, 64'd0);
    host_read(2'd2, v); check("R1 read data after reset", {32'd0, v}, 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    host_write(2'd0, 32'hFFFF_FFFF);
    host_read(2'd0, v); check("R2 command word keeps [10:0]", {32'd0, v}, 64'h7FF);
    host_write(2'd1, 32'hABCD_1234);
    host_read(2'd1, v); check("R10 write data keeps [15:0]", {32'd0, v}, 64'h1234);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    clear_mon();
    host_write(2'd3, 32'h1);
    repeat (30) @(negedge clk);
    check("R4 no MDC edges with enable clear", 64'(rise_n), 64'd0);
    host_read(2'd3, v); check("R4 busy stays 0", {63'd0, v[0]}, 64'd0);
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [31:0] v, rd_before;
    logic [63:0] exp;
    host_read(2'd2, rd_before);
    host_write(2'd0, {21'd0, 1'b0, phy, rg});
    host_write(2'd1, {16'd0, d});
    clear_mon();
    host_write(2'd3, 32'h9);
    host_read(2'd3, v); check("R3 busy reads 1 during write", {63'd0, v[0]}, 64'd1);
    wait_idle("R3 write");
    host_read(2'd3, v); check("R3 busy clear, enable held", {32'd0, v}, 64'h8);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, phy, rg, 2'b10, d};
    check("R6 write bit count", 64'(rise_n), 64'd64);
    check("R6 write frame bits", cap_o, exp);
    check("R6 write drives all bits", cap_oe, '1);
    check("R9 MDC period ns", 64'(period_t), 64'(MDC_PERIOD));
    check("R9 MDIO changes only at MDC fall", 64'(viol), 64'd0);
    check("R9 MDC low when idle", {63'd0, mdc}, 64'd0);
    host_read(2'd2, v); check("R8 write leaves read data", {32'd0, v}, {32'd0, rd_before});
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] pat);
    logic [31:0] v;
    logic [63:0] exp;
    phy_word = pat;
    host_write(2'd0, {21'd0, 1'b1, phy, rg});
    clear_mon();
    host_write(2'd3, 32'h9);
    wait_idle("R8 read");
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg, 18'd0};
    check("R7 read bit count", 64'(rise_n), 64'd64);
    check("R7 read header bits", {cap_o[63:18], 18'd0}, exp);
    check("R7 read drive window", cap_oe, {{46{1'b1}}, 18'd0});
    host_read(2'd2, v); check("R8 read data captured", {32'd0, v}, {48'd0, pat});
  endtask

  task automatic t_restart();
    logic [31:0] v;
    logic [63:0] exp;
    phy_word = 16'hC3A5;
    host_write(2'd0, {21'd0, 1'b1, 5'h0A, 5'h15});
    clear_mon();
    host_write(2'd3, 32'h9);
    repeat (60) @(negedge clk);
    host_write(2'd0, {21'd0, 1'b0, 5'h1F, 5'h00});
    host_write(2'd3, 32'h9);
    wait_idle("R5 restart");
    exp = {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h0A, 5'h15, 18'd0};
    check("R5 restart ignored, bit count", 64'(rise_n), 64'd64);
    check("R5 header kept", {cap_o[63:18], 18'd0}, exp);
    host_read(2'd2, v); check("R5 read result of first frame", {32'd0, v}, 64'hC3A5);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_write(5'h01, 5'h00, 16'h8001);
    t_read(5'h1F, 5'h1F, 16'h8001);
    t_write(5'h15, 5'h0A, 16'h5A3C);
    t_read(5'h03, 5'h11, 16'h5A3C);
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule